// File: doc/BRIEF.md
# Set-Associative Translation Cache with Directory Entries

This block keeps recently used page-table entries for a 32-bit virtual address space with 4 KB pages. A requester presents a 20-bit virtual page number and says whether it wants a leaf entry or a first-level directory entry. In the same cycle the block reports whether that entry is cached. On a hit it returns the 32-bit entry. For a leaf hit it also returns the physical address. The page walker uses directory hits to skip the first memory read of a walk. It writes every entry it fetches through the fill port.

Storage is 16 sets of 4 ways. A leaf request uses the page number itself as the key. A directory request uses the top 10 bits of the page number, zero-extended to 20 bits, as the key. In both cases the low 4 key bits select the set and the upper 16 bits form the tag. Each way keeps a kind flag, so a leaf and a directory entry with the same key never hit for each other. A context-switch flush invalidates every entry except those whose global bit (entry bit 8) is set.

Top module: `xlat_cache`

## Requirements
- R1: After reset, no lookup of either kind hits.
- R2: After a fill, a lookup with the same key and kind hits and returns the filled 32-bit entry in the same cycle as the lookup is presented.
- R3: A hit requires the stored kind flag to equal the requested kind (0 = leaf, 1 = directory); an entry of the other kind with the same key does not hit.
- R4: A directory key is {10'b0, vpn[19:10]}, so directory lookups differing only in vpn[9:0] find the same entry; key bits [3:0] pick the set and [19:4] are the tag for both kinds.
- R5: On a leaf hit the physical address is {entry[31:12], offset[11:0]}; on a directory hit the physical address output is zero.
- R6: On a miss the hit flag, entry and physical address outputs are all zero.
- R7: A fill whose key and kind match no valid entry in the set goes into the lowest-numbered invalid way, so four distinct fills to an empty set all stay resident.
- R8: When a fill finds its set full and no match, it replaces the way named by that set's round-robin pointer, which starts at way 0 and advances by one (mod 4) after each such replacement.
- R9: A fill whose key and kind match a valid entry overwrites that way in place; no other entry is evicted and at most one way hits.
- R10: A flush invalidates every entry with entry bit 8 clear and keeps every entry with bit 8 set.
- R11: A fill in the same cycle as a flush is written and stays valid after that flush.
- R12: A fill and a lookup in the same cycle: the fill is always written, the lookup reports the contents before the fill, and the filled entry hits from the next cycle.
- R13: Fills to one set never change entries of any other set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_dir | input | 1 | Lookup kind: 1 directory, 0 leaf |
| lk_off | input | 12 | Page offset used to build the physical address |
| lk_hit | output | 1 | Lookup hit |
| lk_entry | output | 32 | Cached entry on a hit, zero otherwise |
| lk_paddr | output | 32 | Physical address on a leaf hit, zero otherwise |
| fill_en | input | 1 | Write a fetched entry this cycle |
| fill_vpn | input | 20 | Page number the fill belongs to |
| fill_dir | input | 1 | Fill kind: 1 directory, 0 leaf |
| fill_pte | input | 32 | Entry value to store |
| flush_en | input | 1 | Invalidate all non-global entries |

## Verification
Directed sequences fill one set to capacity and then beyond it. They show that free ways are used before replacement and that the round-robin order evicts the oldest ways in turn. They also show that neighbouring sets are left alone. Leaf and directory entries that share a key, and directory lookups that differ only in the low page-number bits, show the kind check and the directory key folding. A global and a non-global entry placed around a flush that carries a simultaneous fill show which entries survive the flush. Random traffic restricted to a few tags per set forces frequent hits, refreshes and replacements in every set. A bench model built from the requirements predicts each lookup result.

// File: rtl/xc_pkg.sv
package xc_pkg;
  localparam int unsigned VPN_W  = 20;
  localparam int unsigned OFF_W  = 12;
  localparam int unsigned ENT_W  = 32;
  localparam int unsigned DIR_W  = 10;
  localparam int unsigned SETS   = 16;
  localparam int unsigned WAYS   = 4;
  localparam int unsigned GBIT   = 8;
  localparam logic        KIND_LEAF = 1'b0;
  localparam logic        KIND_DIR  = 1'b1;
endpackage

// File: rtl/xc_keygen.sv
module xc_keygen #(
  parameter int unsigned VPN_W = 20,
  parameter int unsigned DIR_W = 10,
  parameter int unsigned IDX_W = 4,
  localparam int unsigned TAG_W = VPN_W - IDX_W
) (
  input  logic [VPN_W-1:0] vpn_i,
  input  logic             dir_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [TAG_W-1:0] tag_o
);
  logic [VPN_W-1:0] key;

  // directory requests fold the upper page-number bits down to the key
  always_comb begin
    key = vpn_i;
    if (dir_i) key = {{(VPN_W-DIR_W){1'b0}}, vpn_i[VPN_W-1 -: DIR_W]};
  end

  assign idx_o = key[IDX_W-1:0];
  assign tag_o = key[VPN_W-1:IDX_W];
endmodule

// File: rtl/xc_store.sv
module xc_store #(
  parameter int unsigned SETS  = 16,
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 16,
  parameter int unsigned ENT_W = 32,
  parameter int unsigned GBIT  = 8,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    flush_i,
  input  logic                                    wr_en_i,
  input  logic [SET_W-1:0]                        wr_set_i,
  input  logic [WAY_W-1:0]                        wr_way_i,
  input  logic [TAG_W-1:0]                        wr_tag_i,
  input  logic                                    wr_dir_i,
  input  logic [ENT_W-1:0]                        wr_data_i,
  output logic [SETS-1:0][WAYS-1:0]               vld_o,
  output logic [SETS-1:0][WAYS-1:0]               dir_o,
  output logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]    tag_o,
  output logic [SETS-1:0][WAYS-1:0][ENT_W-1:0]    data_o
);
  logic [SETS-1:0][WAYS-1:0]            vld_q, vld_n;
  logic [SETS-1:0][WAYS-1:0]            dir_q;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;
  logic [SETS-1:0][WAYS-1:0][ENT_W-1:0] data_q;

  // flush clears non-global slots first, a fill then marks its slot valid
  always_comb begin
    vld_n = vld_q;
    for (int s = 0; s < int'(SETS); s++) begin
      for (int w = 0; w < int'(WAYS); w++) begin
        if (flush_i && !data_q[s][w][GBIT]) vld_n[s][w] = 1'b0;
        if (wr_en_i && wr_set_i == SET_W'(s) && wr_way_i == WAY_W'(w))
          vld_n[s][w] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_n;
  end

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      dir_q[wr_set_i][wr_way_i]  <= wr_dir_i;
      tag_q[wr_set_i][wr_way_i]  <= wr_tag_i;
      data_q[wr_set_i][wr_way_i] <= wr_data_i;
    end
  end

  assign vld_o  = vld_q;
  assign dir_o  = dir_q;
  assign tag_o  = tag_q;
  assign data_o = data_q;

  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> vld_q[$past(wr_set_i)][$past(wr_way_i)]); // R11

  for (genvar gs = 0; gs < SETS; gs++) begin : g_set
    for (genvar gw = 0; gw < WAYS; gw++) begin : g_way
      AST_GLOBAL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_i && vld_q[gs][gw] && data_q[gs][gw][GBIT]) |=> vld_q[gs][gw]); // R10
      AST_LOCAL_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_i && vld_q[gs][gw] && !data_q[gs][gw][GBIT] &&
         !(wr_en_i && wr_set_i == SET_W'(gs) && wr_way_i == WAY_W'(gw)))
        |=> !vld_q[gs][gw]); // R10
    end
  end
endmodule

// File: rtl/xc_victim.sv
module xc_victim #(
  parameter int unsigned SETS  = 16,
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 16,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fill_en_i,
  input  logic [SET_W-1:0]            fill_set_i,
  input  logic [TAG_W-1:0]            fill_tag_i,
  input  logic                        fill_dir_i,
  input  logic [WAYS-1:0]             set_vld_i,
  input  logic [WAYS-1:0]             set_dir_i,
  input  logic [WAYS-1:0][TAG_W-1:0]  set_tag_i,
  output logic [WAY_W-1:0]            way_o
);
  logic [SETS-1:0][WAY_W-1:0] rr_q, rr_n;
  logic [WAYS-1:0]            same_w;
  logic                       use_rr;

  always_comb begin
    for (int w = 0; w < int'(WAYS); w++)
      same_w[w] = set_vld_i[w] && (set_dir_i[w] == fill_dir_i) &&
                  (set_tag_i[w] == fill_tag_i);
  end

  assign use_rr = !(|same_w) && (&set_vld_i);

  // matching way beats free way beats round-robin pointer
  always_comb begin
    way_o = rr_q[fill_set_i];
    for (int w = int'(WAYS) - 1; w >= 0; w--)
      if (!set_vld_i[w]) way_o = WAY_W'(w);
    for (int w = int'(WAYS) - 1; w >= 0; w--)
      if (same_w[w]) way_o = WAY_W'(w);
  end

  always_comb begin
    rr_n = rr_q;
    if (fill_en_i && use_rr) rr_n[fill_set_i] = rr_q[fill_set_i] + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else        rr_q <= rr_n;
  end

  AST_NO_DUP_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en_i |-> $onehot0(same_w)); // R9
  AST_FREE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en_i && !(&set_vld_i) && !(|same_w)) |-> !set_vld_i[way_o]); // R7
  AST_REFRESH_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en_i && (|same_w)) |-> same_w[way_o]); // R9
endmodule

// File: rtl/xc_match.sv
module xc_match #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 16,
  parameter int unsigned ENT_W = 32
) (
  input  logic [WAYS-1:0]             set_vld_i,
  input  logic [WAYS-1:0]             set_dir_i,
  input  logic [WAYS-1:0][TAG_W-1:0]  set_tag_i,
  input  logic [WAYS-1:0][ENT_W-1:0]  set_data_i,
  input  logic [TAG_W-1:0]            tag_i,
  input  logic                        dir_i,
  output logic [WAYS-1:0]             way_hit_o,
  output logic                        hit_o,
  output logic [ENT_W-1:0]            data_o
);
  always_comb begin
    data_o = '0;
    for (int w = 0; w < int'(WAYS); w++) begin
      way_hit_o[w] = set_vld_i[w] && (set_dir_i[w] == dir_i) &&
                     (set_tag_i[w] == tag_i);
      if (way_hit_o[w]) data_o = data_o | set_data_i[w];
    end
  end

  assign hit_o = |way_hit_o;
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xc_pkg::*;
#(
  parameter int unsigned P_VPN_W = VPN_W,
  parameter int unsigned P_OFF_W = OFF_W,
  parameter int unsigned P_ENT_W = ENT_W,
  parameter int unsigned P_DIR_W = DIR_W,
  parameter int unsigned P_SETS  = SETS,
  parameter int unsigned P_WAYS  = WAYS,
  parameter int unsigned P_GBIT  = GBIT,
  localparam int unsigned SET_W  = $clog2(P_SETS),
  localparam int unsigned WAY_W  = $clog2(P_WAYS),
  localparam int unsigned TAG_W  = P_VPN_W - SET_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [P_VPN_W-1:0] lk_vpn,
  input  logic               lk_dir,
  input  logic [P_OFF_W-1:0] lk_off,
  output logic               lk_hit,
  output logic [P_ENT_W-1:0] lk_entry,
  output logic [P_ENT_W-1:0] lk_paddr,
  input  logic               fill_en,
  input  logic [P_VPN_W-1:0] fill_vpn,
  input  logic               fill_dir,
  input  logic [P_ENT_W-1:0] fill_pte,
  input  logic               flush_en
);
  logic [SET_W-1:0] lk_set, fl_set;
  logic [TAG_W-1:0] lk_tag, fl_tag;
  logic [WAY_W-1:0] fl_way;
  logic [P_WAYS-1:0] lk_way_hit;

  logic [P_SETS-1:0][P_WAYS-1:0]              vld, dirf;
  logic [P_SETS-1:0][P_WAYS-1:0][TAG_W-1:0]   tags;
  logic [P_SETS-1:0][P_WAYS-1:0][P_ENT_W-1:0] data;

  xc_keygen #(.VPN_W(P_VPN_W), .DIR_W(P_DIR_W), .IDX_W(SET_W)) u_key_lk (
    .vpn_i(lk_vpn), .dir_i(lk_dir), .idx_o(lk_set), .tag_o(lk_tag));

  xc_keygen #(.VPN_W(P_VPN_W), .DIR_W(P_DIR_W), .IDX_W(SET_W)) u_key_fl (
    .vpn_i(fill_vpn), .dir_i(fill_dir), .idx_o(fl_set), .tag_o(fl_tag));

  xc_victim #(.SETS(P_SETS), .WAYS(P_WAYS), .TAG_W(TAG_W)) u_victim (
    .clk(clk), .rst_n(rst_n), .fill_en_i(fill_en), .fill_set_i(fl_set),
    .fill_tag_i(fl_tag), .fill_dir_i(fill_dir), .set_vld_i(vld[fl_set]),
    .set_dir_i(dirf[fl_set]), .set_tag_i(tags[fl_set]), .way_o(fl_way));

  xc_store #(.SETS(P_SETS), .WAYS(P_WAYS), .TAG_W(TAG_W), .ENT_W(P_ENT_W),
             .GBIT(P_GBIT)) u_store (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_en), .wr_en_i(fill_en),
    .wr_set_i(fl_set), .wr_way_i(fl_way), .wr_tag_i(fl_tag),
    .wr_dir_i(fill_dir), .wr_data_i(fill_pte), .vld_o(vld), .dir_o(dirf),
    .tag_o(tags), .data_o(data));

  xc_match #(.WAYS(P_WAYS), .TAG_W(TAG_W), .ENT_W(P_ENT_W)) u_match (
    .set_vld_i(vld[lk_set]), .set_dir_i(dirf[lk_set]), .set_tag_i(tags[lk_set]),
    .set_data_i(data[lk_set]), .tag_i(lk_tag), .dir_i(lk_dir),
    .way_hit_o(lk_way_hit), .hit_o(lk_hit), .data_o(lk_entry));

  // leaf hits splice the frame number onto the page offset
  assign lk_paddr = (lk_hit && !lk_dir) ?
                    {lk_entry[P_ENT_W-1:P_OFF_W], lk_off} : '0;

  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_entry == '0 && lk_paddr == '0)); // R6
  AST_LEAF_SPLICE: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && !lk_dir) |-> (lk_paddr[P_OFF_W-1:0] == lk_off)); // R5
  AST_DIR_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_dir) |-> (lk_paddr == '0)); // R5
  AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_way_hit)); // R9
endmodule

// File: tb/xlat_cache_bench.sv
module xlat_cache_bench;
  localparam int PER = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [19:0] lk_vpn, fill_vpn;
  logic        lk_dir, fill_dir, fill_en, flush_en;
  logic [11:0] lk_off;
  logic [31:0] fill_pte, lk_entry, lk_paddr;
  logic        lk_hit;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit          m_v [16][4];
  bit          m_d [16][4];
  logic [15:0] m_t [16][4];
  logic [31:0] m_e [16][4];
  int          m_rr[16];

  always #(PER/2) clk = ~clk;

  xlat_cache u_xlat_cache (
    .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_dir(lk_dir),
    .lk_off(lk_off), .lk_hit(lk_hit), .lk_entry(lk_entry),
    .lk_paddr(lk_paddr), .fill_en(fill_en), .fill_vpn(fill_vpn),
    .fill_dir(fill_dir), .fill_pte(fill_pte), .flush_en(flush_en));

  task automatic keyof(input logic [19:0] vpn, input bit d,
                       output int idx, output logic [15:0] tg);
    logic [19:0] k;
    k = d ? {10'b0, vpn[19:10]} : vpn;
    idx = int'(k[3:0]);
    tg  = k[19:4];
  endtask

  task automatic step(input logic [19:0] lv, input bit ld, input logic [11:0] lo,
                      input bit fe, input logic [19:0] fv, input bit fd,
                      input logic [31:0] fp, input bit fl,
                      input int exp_hit, input string req);
    int i, way;
    logic [15:0] tg;
    bit eh, all_v, same;
    logic [31:0] ee, ep;
    @(negedge clk);
    lk_vpn = lv; lk_dir = ld; lk_off = lo;
    fill_en = fe; fill_vpn = fv; fill_dir = fd; fill_pte = fp; flush_en = fl;
    #(PER/4);
    keyof(lv, ld, i, tg);
    eh = 0; ee = '0;
    for (int w = 0; w < 4; w++)
      if (m_v[i][w] && m_d[i][w] == ld && m_t[i][w] == tg) begin
        eh = 1; ee = m_e[i][w];
      end
    ep = (eh && !ld) ? {ee[31:12], lo} : 32'h0;
    checks++;
    if (lk_hit !== eh || lk_entry !== ee || lk_paddr !== ep) begin
      fails++;
      $display("FAIL %s: hit/entry/paddr got %0b/%h/%h expected %0b/%h/%h",
               req, lk_hit, lk_entry, lk_paddr, eh, ee, ep);
    end
    if (exp_hit >= 0) begin
      checks++;
      if (lk_hit !== exp_hit[0]) begin
        fails++;
        $display("FAIL %s: hit got %0b expected %0b", req, lk_hit, exp_hit[0]);
      end
    end
    @(posedge clk);
    way = -1;
    if (fe) begin
      keyof(fv, fd, i, tg);
      all_v = 1; same = 0;
      for (int w = 3; w >= 0; w--) if (!m_v[i][w]) begin way = w; all_v = 0; end
      for (int w = 3; w >= 0; w--)
        if (m_v[i][w] && m_d[i][w] == fd && m_t[i][w] == tg) begin way = w; same = 1; end
      if (!same && all_v) begin way = m_rr[i]; m_rr[i] = (m_rr[i] + 1) % 4; end
    end
    if (fl)
      for (int s = 0; s < 16; s++)
        for (int w = 0; w < 4; w++)
          if (!m_e[s][w][8]) m_v[s][w] = 0;
    if (fe) begin
      m_v[i][way] = 1; m_d[i][way] = fd; m_t[i][way] = tg; m_e[i][way] = fp;
    end
  endtask

  task automatic look(input logic [19:0] v, input bit d, input logic [11:0] o,
                      input int eh, input string req);
    step(v, d, o, 0, 20'h0, 0, 32'h0, 0, eh, req);
  endtask

  task automatic fill(input logic [19:0] v, input bit d, input logic [31:0] p,
                      input string req);
    step(20'h0, 0, 12'h0, 1, v, d, p, 0, -1, req);
  endtask

  initial begin
    #(PER * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run got hung expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int s = 0; s < 16; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < 4; w++) begin
        m_v[s][w] = 0; m_d[s][w] = 0; m_t[s][w] = '0; m_e[s][w] = '0;
      end
    end
    rst_n = 0; lk_vpn = '0; lk_dir = 0; lk_off = '0;
    fill_en = 0; fill_vpn = '0; fill_dir = 0; fill_pte = '0; flush_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    look(20'h12345, 0, 12'h000, 0, "R1");
    look(20'h12000, 1, 12'h000, 0, "R1");
    // same-cycle lookup and fill: old contents first, fill visible next
    step(20'h12345, 0, 12'h9A4, 1, 20'h12345, 0, 32'hABCDE007, 0, 0, "R12");
    look(20'h12345, 0, 12'h9A4, 1, "R12");
    look(20'h12345, 0, 12'h3C1, 1, "R2");
    look(20'h12345, 0, 12'hFFF, 1, "R5");
    look(20'h12345, 1, 12'h000, 0, "R3");
    fill(20'h12345, 1, 32'h00777021, "R4");
    look(20'h123FF, 1, 12'h123, 1, "R4");
    look(20'h12000, 1, 12'h456, 1, "R5");
    look(20'h00048, 0, 12'h000, 0, "R3");
    look(20'h00049, 0, 12'h000, 0, "R6");
    // fill set 9 to capacity, then beyond
    fill(20'h00019, 0, 32'h11111000, "R7");
    fill(20'h00029, 0, 32'h22222000, "R7");
    fill(20'h00039, 0, 32'h33333000, "R7");
    fill(20'h00049, 0, 32'h44444000, "R7");
    look(20'h00019, 0, 12'h001, 1, "R7");
    look(20'h00029, 0, 12'h002, 1, "R7");
    look(20'h00039, 0, 12'h003, 1, "R7");
    look(20'h00049, 0, 12'h004, 1, "R7");
    fill(20'h00059, 0, 32'h55555000, "R8");
    look(20'h00019, 0, 12'h000, 0, "R8");
    look(20'h00029, 0, 12'h000, 1, "R8");
    fill(20'h00069, 0, 32'h66666000, "R8");
    look(20'h00029, 0, 12'h000, 0, "R8");
    look(20'h00039, 0, 12'h000, 1, "R8");
    look(20'h12345, 0, 12'h010, 1, "R13");
    look(20'h123FF, 1, 12'h010, 1, "R13");
    // refresh an existing key in place
    fill(20'h00039, 0, 32'h3A3A3000, "R9");
    look(20'h00039, 0, 12'h0AA, 1, "R9");
    look(20'h00049, 0, 12'h000, 1, "R9");
    look(20'h00059, 0, 12'h000, 1, "R9");
    look(20'h00069, 0, 12'h000, 1, "R9");
    // flush: global survives, local goes, same-cycle fill stays
    fill(20'h00111, 0, 32'h55555100, "R10");
    step(20'h00111, 0, 12'h0, 1, 20'h00222, 0, 32'h66666000, 1, 1, "R11");
    look(20'h00111, 0, 12'h777, 1, "R10");
    look(20'h12345, 0, 12'h000, 0, "R10");
    look(20'h123FF, 1, 12'h000, 0, "R10");
    look(20'h00222, 0, 12'h000, 1, "R11");

    for (int n = 0; n < 3000; n++) begin
      logic [19:0] lv, fv;
      bit ld, fd, fe, fl;
      ld = ($urandom_range(0, 3) == 0);
      fd = ($urandom_range(0, 3) == 0);
      lv = ld ? {10'($urandom_range(0, 63)), 10'($urandom)} : 20'($urandom_range(0, 95));
      fv = fd ? {10'($urandom_range(0, 63)), 10'($urandom)} : 20'($urandom_range(0, 95));
      fe = ($urandom_range(0, 2) == 0);
      fl = ($urandom_range(0, 39) == 0);
      step(lv, ld, 12'($urandom), fe, fv, fd, $urandom, fl, -1, "R2");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule